// File: doc/BRIEF.md
# Butterfly Destination-Tag Router

This block is a single-cycle switching fabric that connects eight request ports to eight delivery ports. It is built from three stages of 2x2 steering elements, with four elements per stage. Each request carries a 3-bit destination. An element looks at one bit of that destination and uses it alone to pick one of its two outputs. The port a request came in on never affects the path it takes. After the last stage, the line a request sits on equals its destination, and the delivered word is registered on that output port.

Two requests can meet at one element and want the same output. When that happens, the request on the element's upper input goes on. The other is dropped from this cycle's fabric, and its `in_ready` stays low. The sender keeps `in_valid`, the destination and the data steady until it sees `in_ready` high. The losing request therefore tries again on the next cycle with no storage inside the fabric. `in_ready` is a combinational function of the requests presented in the same cycle. Each accepted word appears on `out_valid`/`out_data` one clock edge later.

Top module: `bfly_router`

## Requirements
- R1: A request with destination d (a binary value 0..7 on its 3-bit slice of `in_dest`) that is accepted on a clock edge appears on output port d, with its data unchanged, in the cycle after that edge.
- R2: Destination bit 2 is resolved in the first stage, bit 1 in the second and bit 0 in the last. A bit value of 0 sends the request to the element's upper output (the line with that bit clear), and 1 sends it to the lower output. As a result, two requests that share a first-stage element but differ in destination bit 2 both pass in the same cycle.
- R3: The output port a word reaches depends only on its destination, never on the input port that sent it.
- R4: When both inputs of an element are valid and select the same output, the request on the upper input (lower line index) proceeds and the other has `in_ready` low in that cycle.
- R5: `in_ready[s]` is high exactly when request s reaches its output in that cycle. It is never high while `in_valid[s]` is low.
- R6: After reset, and in any cycle following an edge where no request was delivered to port o, `out_valid[o]` is low.
- R7: A stalled request that is held by its sender is delivered exactly once on a later cycle. Every word presented is delivered once, with none lost or duplicated. The number of outputs valid in a cycle equals the number of `in_ready` bits high in the cycle before.
- R8: A request set whose paths share no element output passes in a single cycle. The identity mapping (s to s) and the complement mapping (s to 7-s) both show this.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 8 | Request present, one bit per input port |
| in_dest | input | 24 | Destination, 3 bits per input port, port s at bits [3s+2:3s] |
| in_data | input | 128 | Data word, 16 bits per input port, port s at bits [16s+15:16s] |
| in_ready | output | 8 | Request accepted this cycle, one bit per input port |
| out_valid | output | 8 | Word delivered, one bit per output port |
| out_data | output | 128 | Delivered word, 16 bits per output port |

## Verification
The hardest case to reach is a contention that appears only at the last stage. In that case, both requests have already won their earlier elements, and the loser is chosen by the final destination bit. The bench reaches this case with directed pairs that share only a last-stage element, and with a hotspot in which all eight inputs target one port so that stalls build up across all three stages. Random traffic, with every stalled request held by its sender, then checks through a per-word identifier that nothing is lost or delivered twice.

// File: rtl/bfly_pkg.sv
package bfly_pkg;
   typedef enum logic {
      PORT_UP = 1'b0,
      PORT_DN = 1'b1
   } port_e;

   localparam int MAX_ADDR_W = 6;
endpackage

// File: rtl/bfly_elem.sv
module bfly_elem
   import bfly_pkg::*;
#(
   parameter int AW  = 3,
   parameter int DW  = 16,
   parameter int BIT = 0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [2*AW+DW:0]      in_up,
   input  logic [2*AW+DW:0]      in_dn,
   output logic [2*AW+DW:0]      out_up,
   output logic [2*AW+DW:0]      out_dn
);
   localparam int FW = 2*AW + DW + 1;
   localparam int VB = FW - 1;
   localparam int DL = DW + AW;

   if (BIT < 0 || BIT >= AW) begin : g_bad_bit
      $error("bfly_elem: BIT out of range");
   end

   logic  up_v, dn_v, clash, dn_go;
   port_e up_sel, dn_sel;

   assign up_v   = in_up[VB];
   assign dn_v   = in_dn[VB];
   assign up_sel = port_e'(in_up[DL+BIT]);
   assign dn_sel = port_e'(in_dn[DL+BIT]);
   assign clash  = up_v && dn_v && (up_sel == dn_sel);
   assign dn_go  = dn_v && !clash;

   always_comb begin
      out_up = '0;
      out_dn = '0;
      if (up_v) begin
         if (up_sel == PORT_DN) out_dn = in_up;
         else                   out_up = in_up;
      end
      if (dn_go) begin
         if (dn_sel == PORT_DN) out_dn = in_dn;
         else                   out_up = in_dn;
      end
   end

   AST_UPPER_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      clash |-> ((up_sel == PORT_DN) ? (out_dn == in_up) : (out_up == in_up))); // R4
   AST_STEER_UP: assert property (@(posedge clk) disable iff (!rst_n)
      out_up[VB] |-> !out_up[DL+BIT]); // R2
   AST_STEER_DN: assert property (@(posedge clk) disable iff (!rst_n)
      out_dn[VB] |-> out_dn[DL+BIT]); // R2
   AST_KEEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (up_v || dn_v) |-> (out_up[VB] || out_dn[VB])); // R7
endmodule

// File: rtl/bfly_stage.sv
module bfly_stage #(
   parameter int AW  = 3,
   parameter int DW  = 16,
   parameter int BIT = 0
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [(2**AW)*(2*AW+DW+1)-1:0] lines_in,
   output logic [(2**AW)*(2*AW+DW+1)-1:0] lines_out
);
   localparam int N   = 2**AW;
   localparam int FW  = 2*AW + DW + 1;
   localparam int NEL = N / 2;

   for (genvar e = 0; e < NEL; e++) begin : g_el
      localparam int LO = ((e >> BIT) << (BIT + 1)) | (e & ((1 << BIT) - 1));
      localparam int HI = LO | (1 << BIT);

      bfly_elem #(.AW(AW), .DW(DW), .BIT(BIT)) u_elem (
         .clk    (clk),
         .rst_n  (rst_n),
         .in_up  (lines_in [LO*FW +: FW]),
         .in_dn  (lines_in [HI*FW +: FW]),
         .out_up (lines_out[LO*FW +: FW]),
         .out_dn (lines_out[HI*FW +: FW])
      );
   end
endmodule

// File: rtl/bfly_ack.sv
module bfly_ack #(
   parameter int AW = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [2**AW-1:0]     fab_valid,
   input  logic [(2**AW)*AW-1:0] fab_src,
   output logic [2**AW-1:0]     ready
);
   localparam int N = 2**AW;

   always_comb begin
      ready = '0;
      for (int o = 0; o < N; o++) begin
         if (fab_valid[o]) ready[fab_src[o*AW +: AW]] = 1'b1;
      end
   end

   AST_GRANT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(ready) == $countones(fab_valid)); // R7
endmodule

// File: rtl/bfly_router.sv
module bfly_router
   import bfly_pkg::*;
#(
   parameter int ADDR_W = 3,
   parameter int DATA_W = 16
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [2**ADDR_W-1:0]         in_valid,
   input  logic [(2**ADDR_W)*ADDR_W-1:0] in_dest,
   input  logic [(2**ADDR_W)*DATA_W-1:0] in_data,
   output logic [2**ADDR_W-1:0]         in_ready,
   output logic [2**ADDR_W-1:0]         out_valid,
   output logic [(2**ADDR_W)*DATA_W-1:0] out_data
);
   localparam int N  = 2**ADDR_W;
   localparam int FW = 2*ADDR_W + DATA_W + 1;
   localparam int VB = FW - 1;
   localparam int SL = DATA_W;
   localparam int DL = DATA_W + ADDR_W;

   if (ADDR_W < 1 || ADDR_W > MAX_ADDR_W) begin : g_bad_aw
      $error("bfly_router: ADDR_W out of range");
   end
   if (DATA_W < 1) begin : g_bad_dw
      $error("bfly_router: DATA_W must be positive");
   end

   logic [N*FW-1:0]      lane [ADDR_W+1];
   logic [N-1:0]         fab_valid;
   logic [N*ADDR_W-1:0]  fab_src;
   logic [N*ADDR_W-1:0]  fab_dest;
   logic [N*DATA_W-1:0]  fab_data;

   always_comb begin
      for (int s = 0; s < N; s++) begin
         lane[0][s*FW +: FW] = {in_valid[s], in_dest[s*ADDR_W +: ADDR_W],
                                ADDR_W'(s), in_data[s*DATA_W +: DATA_W]};
      end
   end

   for (genvar k = 0; k < ADDR_W; k++) begin : g_stage
      bfly_stage #(.AW(ADDR_W), .DW(DATA_W), .BIT(ADDR_W-1-k)) u_stage (
         .clk       (clk),
         .rst_n     (rst_n),
         .lines_in  (lane[k]),
         .lines_out (lane[k+1])
      );
   end

   for (genvar o = 0; o < N; o++) begin : g_out
      assign fab_valid[o]                 = lane[ADDR_W][o*FW + VB];
      assign fab_src [o*ADDR_W +: ADDR_W] = lane[ADDR_W][o*FW + SL +: ADDR_W];
      assign fab_dest[o*ADDR_W +: ADDR_W] = lane[ADDR_W][o*FW + DL +: ADDR_W];
      assign fab_data[o*DATA_W +: DATA_W] = lane[ADDR_W][o*FW +: DATA_W];

      AST_DEST_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
         fab_valid[o] |-> (fab_dest[o*ADDR_W +: ADDR_W] == ADDR_W'(o))); // R1
   end

   bfly_ack #(.AW(ADDR_W)) u_ack (
      .clk       (clk),
      .rst_n     (rst_n),
      .fab_valid (fab_valid),
      .fab_src   (fab_src),
      .ready     (in_ready)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= '0;
         out_data  <= '0;
      end else begin
         out_valid <= fab_valid;
         out_data  <= fab_data;
      end
   end

   AST_READY_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (in_ready & ~in_valid) == '0); // R5
   AST_OUT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(out_valid) == $countones($past(in_ready))); // R7
endmodule

// File: tb/sim_bfly_router.sv
`timescale 1ns/1ps
module sim_bfly_router;
   localparam int N  = 8;
   localparam int AW = 3;
   localparam int DW = 16;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [N-1:0]    in_valid;
   logic [N*AW-1:0] in_dest;
   logic [N*DW-1:0] in_data;
   logic [N-1:0]    in_ready;
   logic [N-1:0]    out_valid;
   logic [N*DW-1:0] out_data;

   always #10 clk = ~clk;

   bfly_router #(.ADDR_W(AW), .DATA_W(DW)) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dest(in_dest),
      .in_data(in_data), .in_ready(in_ready), .out_valid(out_valid),
      .out_data(out_data)
   );

   int nchk = 0, nfail = 0, sent = 0, got = 0, next_id = 0;
   bit done = 0;
   bit          pv   [N];
   logic [2:0]  pd   [N];
   logic [15:0] pdat [N];
   int          exp_dst [4096];
   bit          seen    [4096];
   logic [N-1:0]    rdy, ov;
   logic [N*DW-1:0] od;

   task automatic check(input bit ok, input string req,
                        input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic new_req(input int s, input int d);
      exp_dst[next_id] = d;
      seen[next_id]    = 1'b0;
      pv[s]   = 1'b1;
      pd[s]   = 3'(d);
      pdat[s] = {4'(s), 12'(next_id)};
      next_id = (next_id + 1) % 4096;
      sent++;
   endtask

   // One fabric cycle: present pending requests, sample ready, sample outputs.
   task automatic run_cycle();
      @(negedge clk);
      for (int s = 0; s < N; s++) begin
         in_valid[s]          = pv[s];
         in_dest[s*AW +: AW]  = pd[s];
         in_data[s*DW +: DW]  = pdat[s];
      end
      #1 rdy = in_ready;
      if ((rdy & ~in_valid) != 0)
         check(1'b0, "R5 ready without valid", rdy, in_valid);
      @(posedge clk);
      #1 ov = out_valid; od = out_data;
      for (int o = 0; o < N; o++) begin
         if (ov[o]) begin
            int id = int'(od[o*DW +: 12]);
            if (exp_dst[id] != o) check(1'b0, "R1 wrong port", o, exp_dst[id]);
            if (seen[id])         check(1'b0, "R7 duplicate", id, 0);
            seen[id] = 1'b1;
            got++;
         end
      end
      if ($countones(ov) != $countones(rdy))
         check(1'b0, "R7 count", ov, rdy);
      for (int s = 0; s < N; s++) if (rdy[s]) pv[s] = 1'b0;
   endtask

   task automatic t_reset();
      check(out_valid == 0, "R6 reset out_valid", out_valid, 0);
      check(in_ready == 0, "R5 idle ready", in_ready, 0);
      run_cycle();
      check(ov == 0, "R6 idle out_valid", ov, 0);
   endtask

   task automatic t_all_pairs();
      int bad = 0;
      for (int s = 0; s < N; s++) begin
         for (int d = 0; d < N; d++) begin
            new_req(s, d);
            run_cycle();
            if (rdy != (8'h1 << s)) begin
               bad++; check(1'b0, "R5 single ready", rdy, 8'h1 << s);
            end
            if (ov != (8'h1 << d) || od[d*DW +: DW] != {4'(s), 12'(next_id - 1)}) begin
               bad++; check(1'b0, "R1 R3 delivery port/data", ov, 8'h1 << d);
            end
            run_cycle();
            if (ov != 0) begin bad++; check(1'b0, "R6 drop after idle", ov, 0); end
         end
      end
      check(bad == 0, "R1 R3 all 64 pairs", bad, 0);
   endtask

   task automatic t_stage2_steer();
      new_req(0, 0); new_req(4, 4);
      run_cycle();
      check(rdy == 8'h11, "R2 differing bit2 both pass", rdy, 8'h11);
      check(ov == 8'h11, "R2 outputs 0 and 4", ov, 8'h11);
   endtask

   task automatic t_clash_first();
      new_req(0, 0); new_req(4, 1);
      run_cycle();
      check(rdy == 8'h01, "R4 first-stage clash upper wins", rdy, 8'h01);
      run_cycle();
      check(rdy == 8'h10, "R7 stalled retried", rdy, 8'h10);
      check(ov == 8'h02, "R7 stalled delivered to 1", ov, 8'h02);
   endtask

   task automatic t_clash_last();
      new_req(0, 5); new_req(1, 5);
      run_cycle();
      check(rdy == 8'h01, "R4 last-stage clash upper wins", rdy, 8'h01);
      check(ov == 8'h20, "R1 port 5", ov, 8'h20);
      run_cycle();
      check(rdy == 8'h02, "R7 last-stage loser retried", rdy, 8'h02);
   endtask

   task automatic t_hotspot();
      int cyc = 0;
      int bad = 0;
      for (int s = 0; s < N; s++) new_req(s, 3);
      run_cycle();
      check(rdy == 8'h01, "R4 hotspot first winner", rdy, 8'h01);
      cyc = 1;
      while ((pv[0] | pv[1] | pv[2] | pv[3] | pv[4] | pv[5] | pv[6] | pv[7]) && cyc < 20) begin
         run_cycle();
         if ($countones(rdy) != 1) bad++;
         cyc++;
      end
      check(bad == 0, "R4 one grant per cycle", bad, 0);
      check(cyc == 8, "R7 hotspot drains in 8", cyc, 8);
   endtask

   task automatic t_perms();
      for (int s = 0; s < N; s++) new_req(s, s);
      run_cycle();
      check(rdy == 8'hFF, "R8 identity one cycle", rdy, 8'hFF);
      for (int s = 0; s < N; s++) new_req(s, 7 - s);
      run_cycle();
      check(rdy == 8'hFF, "R8 complement one cycle", rdy, 8'hFF);
      check(ov == 8'hFF, "R8 complement outputs", ov, 8'hFF);
   endtask

   task automatic t_random();
      int s0 = sent, g0 = got, k = 0;
      for (int c = 0; c < 2000; c++) begin
         for (int s = 0; s < N; s++)
            if (!pv[s] && ($urandom % 2 == 0)) new_req(s, int'($urandom % N));
         run_cycle();
      end
      while ((pv[0] | pv[1] | pv[2] | pv[3] | pv[4] | pv[5] | pv[6] | pv[7]) && k < 50) begin
         run_cycle(); k++;
      end
      run_cycle();
      check((sent - s0) == (got - g0), "R7 random no loss", got - g0, sent - s0);
   endtask

   initial begin
      in_valid = '0; in_dest = '0; in_data = '0;
      for (int s = 0; s < N; s++) begin pv[s] = 0; pd[s] = 0; pdat[s] = 0; end
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      #1;
      t_reset();
      t_all_pairs();
      t_stage2_steer();
      t_clash_first();
      t_clash_last();
      t_hotspot();
      t_perms();
      t_random();
      check(got == sent, "R7 total delivered", got, sent);
      if (!done) begin
         done = 1;
         $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         nchk++; nfail++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
         $finish;
      end
   end
endmodule